// File: doc/BRIEF.md
# Block-Skipping Carry-Lookahead Adder

This block adds two unsigned or two's-complement words and an incoming carry in one combinational pass. The operand width is cut into equal slices. Each slice looks at its own columns and condenses them into two summary bits. One bit says that the slice creates a carry by itself. The other says that it passes an incoming carry straight through.

The carry travels between slices through a single AND-OR term per slice, so it moves a whole slice at a time instead of one bit at a time. Inside a slice, the sum bits come from a short local carry chain. That chain starts from the carry entering the slice.

The default is a 32-bit word made of eight 4-bit slices. The width must be a whole multiple of the slice size. Any other pairing stops elaboration with an error. The block has no clock and no state, so it can be dropped into any datapath stage.

Top module: `cla_block_adder`

## Requirements
- R1: For every input, {c_out, sum_out} equals a_in + b_in + c_in as an unsigned (WIDTH+1)-bit value. With all inputs zero, both outputs are zero.
- R2: When a_in is all ones and c_in is 1, a carry crosses every slice. With b_in all zeros the result is sum_out = 0 and c_out = 1. With b_in all ones the result is sum_out all ones and c_out = 1.
- R3: The carry entering slice j (bits j*SPAN and up) equals bit j*SPAN of the sum of the operand bits below that position plus c_in. A carry born in a low slice therefore reaches every higher sum bit it should.
- R4: A slice in which every column holds exactly one 1 passes its incoming carry unchanged to the next slice.
- R5: A slice that generates a carry of its own sends a 1 to the next slice, whatever its incoming carry.
- R6: A slice that neither generates a carry nor propagates across all of its columns sends a 0 to the next slice, whatever its incoming carry.
- R7: R1 holds for other legal shapes, including a 2-bit slice in an 8-bit word and a single slice that covers a 6-bit word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First addend |
| b_in | input | WIDTH | Second addend |
| c_in | input | 1 | Carry into the least significant column |
| sum_out | output | WIDTH | Sum bits |
| c_out | output | 1 | Carry leaving the most significant slice |

## Verification
A wrong slice summary shows up as a mismatch that appears at once, in the same evaluation. The mismatch sits at the first sum bit of the next slice. It then spreads into every higher bit that a carry should reach. A slice that wrongly skips or wrongly blocks a carry corrupts c_out only when the operands happen to form a carry path through that slice.

For this reason the checks use operand patterns that force each kind of path. These are full propagation, a carry generated low in the word, and a slice that kills the carry. They also sweep small shapes exhaustively, so that every slice boundary sees every combination.

// File: rtl/cla_block_adder.sv
module cla_block_adder #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned SPAN  = 4
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             c_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             c_out
);
  localparam int unsigned NBLK = WIDTH / SPAN;

  if (SPAN == 0 || (WIDTH % SPAN) != 0) begin : g_shape_bad
    $error("cla_block_adder: WIDTH must be a multiple of SPAN");
  end

  logic [WIDTH-1:0] gen, prp;
  logic [NBLK-1:0]  blk_g, blk_p;
  logic [NBLK:0]    hop;

  assign gen = a_in & b_in;
  assign prp = a_in | b_in;

  always_comb begin
    logic run;
    hop[0]  = c_in;
    sum_out = '0;
    for (int j = 0; j < NBLK; j++) begin
      blk_g[j] = 1'b0;
      blk_p[j] = 1'b1;
      for (int i = 0; i < SPAN; i++) begin
        blk_g[j] = gen[j*SPAN+i] | (prp[j*SPAN+i] & blk_g[j]);
        blk_p[j] = blk_p[j] & prp[j*SPAN+i];
      end
      hop[j+1] = blk_g[j] | (blk_p[j] & hop[j]);
      run = hop[j];
      for (int i = 0; i < SPAN; i++) begin
        sum_out[j*SPAN+i] = a_in[j*SPAN+i] ^ b_in[j*SPAN+i] ^ run;
        run = gen[j*SPAN+i] | (prp[j*SPAN+i] & run);
      end
    end
  end

  assign c_out = hop[NBLK];

  logic [WIDTH:0] full_ref, lo_mask, lo_sum;
  always_comb begin
    full_ref = {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, c_in};
    p_sum_r1: assert ({c_out, sum_out} == full_ref)
      else $error("R1 sum mismatch");
    lo_mask = '0;
    lo_sum  = '0;
    for (int j = 1; j <= NBLK; j++) begin
      lo_mask = ((WIDTH+1)'(1) << (j*SPAN)) - (WIDTH+1)'(1);
      lo_sum  = ({1'b0, a_in} & lo_mask) + ({1'b0, b_in} & lo_mask)
              + {{WIDTH{1'b0}}, c_in};
      p_hop_r3: assert (hop[j] == lo_sum[j*SPAN])
        else $error("R3 slice carry mismatch");
    end
    for (int j = 0; j < NBLK; j++) begin
      if (blk_p[j] && !blk_g[j]) begin
        p_skip_r4: assert (hop[j+1] == hop[j]) else $error("R4 skip broken");
      end
      if (blk_g[j]) begin
        p_gen_r5: assert (hop[j+1]) else $error("R5 generate lost");
      end
      if (!blk_g[j] && !blk_p[j]) begin
        p_kill_r6: assert (!hop[j+1]) else $error("R6 kill broken");
      end
    end
  end
endmodule

// File: tb/sim_cla_block_adder.sv
`timescale 1ns/1ps
module sim_cla_block_adder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [31:0] a0, b0, s0; logic c0, co0;
  logic [7:0]  a1, b1, s1; logic c1, co1;
  logic [5:0]  a2, b2, s2; logic c2, co2;

  cla_block_adder u0 (.a_in(a0), .b_in(b0), .c_in(c0), .sum_out(s0), .c_out(co0));
  cla_block_adder #(.WIDTH(8), .SPAN(2)) u1 (.a_in(a1), .b_in(b1), .c_in(c1), .sum_out(s1), .c_out(co1));
  cla_block_adder #(.WIDTH(6), .SPAN(6)) u2 (.a_in(a2), .b_in(b2), .c_in(c2), .sum_out(s2), .c_out(co2));

  task automatic chk32(input string tag, input logic [31:0] a, input logic [31:0] b, input logic c);
    logic [32:0] exp;
    a0 = a; b0 = b; c0 = c;
    #2;
    exp = {1'b0, a} + {1'b0, b} + {32'd0, c};
    tests++;
    if ({co0, s0} !== exp) begin
      fails++;
      $display("FAIL %s: a=%h b=%h c=%b got %h expected %h", tag, a, b, c, {co0, s0}, exp);
    end
  endtask

  initial begin
    a0 = '0; b0 = '0; c0 = 1'b0;
    a1 = '0; b1 = '0; c1 = 1'b0;
    a2 = '0; b2 = '0; c2 = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk32("R1 zero", 32'h0, 32'h0, 1'b0);
    chk32("R2 ones+cin", 32'hFFFF_FFFF, 32'h0, 1'b1);
    chk32("R2 ones+ones+cin", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    chk32("R3 low carry reaches slice 3", 32'h0000_0FFF, 32'h0000_0001, 1'b0);
    chk32("R3 cin to top", 32'h7FFF_FFFF, 32'h0, 1'b1);
    chk32("R4 skip cin=1", 32'h5555_5555, 32'hAAAA_AAAA, 1'b1);
    chk32("R4 skip cin=0", 32'h5555_5555, 32'hAAAA_AAAA, 1'b0);
    chk32("R4 skip mixed", 32'h3C3C_3C3C, 32'hC3C3_C3C3, 1'b1);
    chk32("R5 generate cin=0", 32'h0000_0008, 32'h0000_0008, 1'b0);
    chk32("R5 generate cin=1", 32'h0000_0008, 32'h0000_0008, 1'b1);
    chk32("R5 top generate", 32'h8000_0000, 32'h8000_0000, 1'b0);
    chk32("R6 kill above carry", 32'h0000_000F, 32'h0000_0001, 1'b1);
    chk32("R6 kill in middle", 32'hF00F_FFFF, 32'h0000_0001, 1'b0);
    chk32("R1 alt", 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1);
    for (int n = 0; n < 3000; n++)
      chk32("R1 random", $urandom, $urandom, 1'($urandom));
    for (int v = 0; v < (1 << 17); v++) begin
      logic [8:0] exp;
      {c1, a1, b1} = 17'(v);
      #2;
      exp = {1'b0, a1} + {1'b0, b1} + {8'd0, c1};
      tests++;
      if ({co1, s1} !== exp) begin
        fails++;
        $display("FAIL R7 8/2: a=%h b=%h c=%b got %h expected %h", a1, b1, c1, {co1, s1}, exp);
      end
    end
    for (int v = 0; v < (1 << 13); v++) begin
      logic [6:0] exp;
      {c2, a2, b2} = 13'(v);
      #2;
      exp = {1'b0, a2} + {1'b0, b2} + {6'd0, c2};
      tests++;
      if ({co2, s2} !== exp) begin
        fails++;
        $display("FAIL R7 6/6: a=%h b=%h c=%b got %h expected %h", a2, b2, c2, {co2, s2}, exp);
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #900_000;
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule